// File: doc/BRIEF.md
# Shaped PRBS Test-Pattern Source

This block is a serial test-pattern source. It emits one bit of a pseudo-random binary sequence on every enabled clock. Six maximal-length sequences are available. Three optional shaping stages act on the stream, in a fixed order. The first stage sets the fraction of ones by combining neighbouring sequence bits. The second stage stretches the longest zero run of each period and closes it with a forced one. The last stage can invert the stream. A trigger pulse marks the start of every fourth complete pattern period, so that an oscilloscope or an error counter can lock to the pattern.

All settings are sampled only on the first bit of a period. A change made in the middle of a period therefore never produces a corrupted partial pattern. The enable input pauses the source without losing its place in the pattern. It is meant to feed a serialiser or a receiver under test inside a test fabric.

Top module: `prbs_shaper`

## Requirements
- R1: `poly_sel` selects the sequence: 0 = length 7, 1 = length 10, 2 = length 11, 3 = length 15, 4 = length 23, 5 = length 31, and 6 or 7 = length 7. For length n with second tap t (7:6, 10:7, 11:9, 15:14, 23:18, 31:28), the raw bits of a period obey b[k] = b[k-n] xor b[k-t]. Each period starts with b[0..n-2] = 0 and b[n-1] = 1.
- R2: Every period lasts 2^n-1 enabled cycles. After reset, the first enabled bit is bit 0 of a period, and periods follow one another without gaps.
- R3: `dens_sel` sets the fraction of ones: 0 = 1/2, where output bit k is b[k]; 1 = 1/4, where it is b[k]&b[k+1]; 2 = 1/8, where it is b[k]&b[k+1]&b[k+2]; 3 = 3/4, where it is b[k]|b[k+1]; 4 = 7/8, where it is b[k]|b[k+1]|b[k+2]. Codes 5 to 7 act as 1/2. Indices wrap into the next period.
- R4: Let z = `zero_ext`. When z > 0, positions n-1 to n-2+z of the period are forced to 0 and position n-1+z is forced to 1. This is applied after the density stage.
- R5: z is limited to 2^n-1-n, so the stretched zero run is at most one bit shorter than the period.
- R6: When `invert` is 1, the output bit is the complement of the shaped bit. Inversion is the last stage.
- R7: `trig` is high for exactly one bit: bit 0 of the 1st, 5th, 9th, and so on, period counted from reset. It is never high at any other time.
- R8: The settings `poly_sel`, `zero_ext`, `dens_sel` and `invert` take effect only on bit 0 of a period. Changes at other times have no effect until the next period starts.
- R9: While `en` is low, `dvalid` and `trig` are low, `dout` holds its value, and the pattern resumes where it stopped.
- R10: During reset and after it, `dout`, `dvalid` and `trig` are 0 until the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poly_sel | input | 3 | Sequence length select |
| zero_ext | input | ZW | Number of extra zeros added to the longest run |
| dens_sel | input | 3 | Fraction-of-ones select |
| invert | input | 1 | Output polarity |
| en | input | 1 | Advance the pattern by one bit |
| dout | output | 1 | Pattern bit, registered |
| dvalid | output | 1 | `dout` carries a new bit |
| trig | output | 1 | Pulse on bit 0 of every fourth period |

## Verification
The hardest situations to reach from the ports are three corner cases:
- a setting that changes part-way through a period and must stay ignored;
- a pause inside a period;
- the clamp on the zero run.

The bench reaches them by scheduling the changes relative to the enabled cycle count. Inside one run it flips polarity and density halfway through the last period. It drops `en` for several cycles inside a period. It requests more zeros than the shortest sequence can hold.

A scoreboard compares every bit against a model built from the recurrence. The model checks all six lengths: complete periods for 7, 10, 11 and 15, and a prefix after reset for 23 and 31.

// File: rtl/prbs_shaper.sv
module prbs_shaper #(
  parameter int ZW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    poly_sel,
  input  logic [ZW-1:0] zero_ext,
  input  logic [2:0]    dens_sel,
  input  logic          invert,
  input  logic          en,
  output logic          dout,
  output logic          dvalid,
  output logic          trig
);
  logic [30:0]   lfsr, pos;
  logic [1:0]    rep;
  logic [2:0]    h_poly, h_dens;
  logic [ZW-1:0] h_zero;
  logic          h_inv;

  wire at_start = (pos == '0);
  wire [2:0]    c_poly = at_start ? poly_sel : h_poly;
  wire [2:0]    c_dens = at_start ? dens_sel : h_dens;
  wire [ZW-1:0] c_zero = at_start ? zero_ext : h_zero;
  wire          c_inv  = at_start ? invert   : h_inv;

  logic [4:0] n, tp;
  always_comb begin
    case (c_poly)
      3'd1:    begin n = 5'd10; tp = 5'd7;  end
      3'd2:    begin n = 5'd11; tp = 5'd9;  end
      3'd3:    begin n = 5'd15; tp = 5'd14; end
      3'd4:    begin n = 5'd23; tp = 5'd18; end
      3'd5:    begin n = 5'd31; tp = 5'd28; end
      default: begin n = 5'd7;  tp = 5'd6;  end
    endcase
  end

  wire [31:0] plen = (32'd1 << n) - 32'd1;
  wire [31:0] zmax = plen - 32'(n);
  wire [31:0] zreq = 32'(c_zero);
  wire [31:0] zeff = (zreq > zmax) ? zmax : zreq;
  wire [31:0] nm1  = 32'(n) - 32'd1;
  wire [31:0] p32  = {1'b0, pos};
  wire        last = (p32 == plen - 32'd1);

  wire        fb  = lfsr[n - 5'd1] ^ lfsr[tp - 5'd1];
  wire [30:0] nxt = {lfsr[29:0], fb} & plen[30:0];

  wire b0 = lfsr[n - 5'd1];
  wire b1 = lfsr[n - 5'd2];
  wire b2 = lfsr[n - 5'd3];

  logic dbit, sbit;
  always_comb begin
    case (c_dens)
      3'd1:    dbit = b0 & b1;
      3'd2:    dbit = b0 & b1 & b2;
      3'd3:    dbit = b0 | b1;
      3'd4:    dbit = b0 | b1 | b2;
      default: dbit = b0;
    endcase
    sbit = dbit;
    if (zeff != '0) begin
      if (p32 >= nm1 && p32 < nm1 + zeff) sbit = 1'b0;
      else if (p32 == nm1 + zeff)         sbit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr   <= 31'd1;
      pos    <= '0;
      rep    <= '0;
      h_poly <= '0;
      h_dens <= '0;
      h_zero <= '0;
      h_inv  <= 1'b0;
      dout   <= 1'b0;
      dvalid <= 1'b0;
      trig   <= 1'b0;
    end else begin
      dvalid <= en;
      trig   <= en && at_start && (rep == 2'd0);
      if (en) begin
        dout   <= sbit ^ c_inv;
        lfsr   <= nxt;
        pos    <= last ? '0 : pos + 31'd1;
        if (last) rep <= rep + 2'd1;
        h_poly <= c_poly;
        h_dens <= c_dens;
        h_zero <= c_zero;
        h_inv  <= c_inv;
      end
    end
  end
endmodule

module prbs_shaper_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        dout,
  input logic        dvalid,
  input logic        trig,
  input logic [30:0] lfsr
);
  // R9
  idle_novalid_chk: assert property (@(posedge clk) disable iff (rst) !en |=> !dvalid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(dout));
  // R7
  trig_valid_chk: assert property (@(posedge clk) disable iff (rst) trig |-> dvalid);
  // R7
  trig_single_chk: assert property (@(posedge clk) disable iff (rst) trig |=> !trig);
  // R1
  state_live_chk: assert property (@(posedge clk) disable iff (rst) $countones(lfsr) != 0);
endmodule

bind prbs_shaper prbs_shaper_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout),
  .dvalid(dvalid), .trig(trig), .lfsr(lfsr)
);

// File: tb/prbs_shaper_bench.sv
`timescale 1ns/1ps
module prbs_shaper_bench;
  localparam int ZW = 16;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    poly_sel = '0;
  logic [ZW-1:0] zero_ext = '0;
  logic [2:0]    dens_sel = '0;
  logic          invert = 1'b0;
  logic          en = 1'b0;
  logic          dout, dvalid, trig;

  prbs_shaper #(.ZW(ZW)) u_prbs_shaper (
    .clk(clk), .rst(rst), .poly_sel(poly_sel), .zero_ext(zero_ext),
    .dens_sel(dens_sel), .invert(invert), .en(en),
    .dout(dout), .dvalid(dvalid), .trig(trig)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  int    percount = 0;
  bit    q_d[$];
  bit    q_t[$];
  string q_tag[$];
  bit    last_d = 1'b0;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual hung, expected finish");
    summary();
    $finish;
  end

  always @(negedge clk) begin
    if (rst) last_d = 1'b0;
    else if (dvalid) begin
      checks++;
      if (q_d.size() == 0) begin
        fails++;
        $display("FAIL R9 valid with nothing expected: actual dvalid=1, expected 0");
      end else begin
        bit ed, et; string tg;
        ed = q_d.pop_front(); et = q_t.pop_front(); tg = q_tag.pop_front();
        if (dout !== ed) begin
          fails++;
          $display("FAIL %s data: actual %0b, expected %0b", tg, dout, ed);
        end
        checks++;
        if (trig !== et) begin
          fails++;
          $display("FAIL R7 trigger: actual %0b, expected %0b", trig, et);
        end
      end
      last_d = dout;
    end else begin
      checks++;
      if (dout !== last_d || trig !== 1'b0) begin
        fails++;
        $display("FAIL R9 idle: actual dout=%0b trig=%0b, expected dout=%0b trig=0",
                 dout, trig, last_d);
      end
    end
  end

  function automatic int len_of(int sel);
    case (sel)
      1: return 10; 2: return 11; 3: return 15; 4: return 23; 5: return 31;
      default: return 7;
    endcase
  endfunction

  function automatic int tap_of(int sel);
    case (sel)
      1: return 7; 2: return 9; 3: return 14; 4: return 18; 5: return 28;
      default: return 6;
    endcase
  endfunction

  task automatic push_bits(input int sel, input int z, input int dens, input bit inv,
                           input int nper, input int partial);
    int n, t, p, zeff, cnt;
    bit raw[];
    n = len_of(sel); t = tap_of(sel);
    cnt = (partial > 0) ? partial : 0;
    p = (n == 31) ? 0 : ((1 << n) - 1);
    if (partial > 0) raw = new[partial + 2];
    else raw = new[p + 2];
    for (int k = 0; k < raw.size(); k++) begin
      if (k < n - 1) raw[k] = 1'b0;
      else if (k == n - 1) raw[k] = 1'b1;
      else raw[k] = raw[k - n] ^ raw[k - t];
    end
    zeff = z;
    if (n < 31 && z > p - n) zeff = p - n;
    for (int r = 0; r < ((partial > 0) ? 1 : nper); r++) begin
      for (int k = 0; k < ((partial > 0) ? cnt : p); k++) begin
        bit d; string tg;
        case (dens)
          1: d = raw[k] & raw[k+1];
          2: d = raw[k] & raw[k+1] & raw[k+2];
          3: d = raw[k] | raw[k+1];
          4: d = raw[k] | raw[k+1] | raw[k+2];
          default: d = raw[k];
        endcase
        tg = (dens inside {[1:4]}) ? "R3" : "R1";
        if (zeff > 0) begin
          if (k >= n - 1 && k < n - 1 + zeff) begin d = 1'b0; tg = (z != zeff) ? "R5" : "R4"; end
          else if (k == n - 1 + zeff) begin d = 1'b1; tg = (z != zeff) ? "R5" : "R4"; end
        end
        if (inv) begin d = ~d; tg = "R6"; end
        if (k == 0) tg = "R2";
        q_d.push_back(d);
        q_t.push_back(k == 0 && (percount % 4) == 0);
        q_tag.push_back(tg);
      end
      if (partial == 0) percount++;
    end
  endtask

  task automatic run(input int sel, input int z, input int dens, input bit inv,
                     input int nper, input int partial, input int gap_at, input int glitch_at);
    int total;
    push_bits(sel, z, dens, inv, nper, partial);
    total = (partial > 0) ? partial : ((1 << len_of(sel)) - 1) * nper;
    poly_sel = sel[2:0]; zero_ext = z[ZW-1:0]; dens_sel = dens[2:0]; invert = inv;
    en = 1'b1;
    for (int c = 1; c <= total; c++) begin
      @(negedge clk);
      if (c == glitch_at) begin
        invert = ~inv; dens_sel = 3'd2; zero_ext = 16'd3; poly_sel = 3'd1;
      end
      if (c == gap_at && c != total) begin
        en = 1'b0;
        repeat (4) @(negedge clk);
        en = 1'b1;
      end
    end
    en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (dout !== 1'b0 || dvalid !== 1'b0 || trig !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual %0b%0b%0b, expected 000", dout, dvalid, trig);
    end
    rst = 1'b0;
    percount = 0;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    run(0, 0, 0, 0, 2, 0, 0, 0);
    run(0, 0, 1, 0, 1, 0, 0, 0);
    run(0, 0, 2, 0, 1, 0, 0, 0);
    run(0, 0, 3, 0, 1, 0, 0, 0);
    run(0, 0, 4, 0, 1, 0, 40, 0);
    // R8: settings flipped mid-period must not disturb the running period
    run(6, 0, 0, 1, 2, 0, 0, 190);
    run(0, 10, 0, 0, 1, 0, 0, 0);
    run(0, 200, 0, 0, 1, 0, 0, 60);
    run(1, 0, 3, 0, 1, 0, 500, 0);
    run(2, 5, 0, 1, 1, 0, 0, 0);
    run(3, 0, 0, 0, 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    do_reset();
    run(4, 0, 0, 0, 1, 300, 0, 0);
    @(negedge clk);
    do_reset();
    run(5, 2, 2, 0, 1, 300, 0, 0);
    @(negedge clk);
    do_reset();
    checks++;
    if (q_d.size() != 0) begin
      fails++;
      $display("FAIL R2 missing bits: actual %0d left, expected 0", q_d.size());
    end
    summary();
    $finish;
  end
endmodule